// File: doc/BRIEF.md
# Flash Bus Operation Decoder

This block sits behind the pads of a parallel flash device. It turns the asynchronous control pins (chip enable, output enable, write enable, hardware reset and the byte/word select) into clean operations for the rest of the device. It samples every pin with a fast internal clock. It filters the strobes against short noise pulses and classifies each sampled state as reset, standby, output disable, read or write. For a read it raises a read strobe and enables the data output drivers byte by byte. For a write it captures address and data and hands them to the command logic as a single-cycle pulse when the write strobe returns high.

Two protections guard against writes nobody intended. The first is the minimum-width filter on the strobes. The second is a power-up interlock: a write condition that is already present when the device comes out of reset is never accepted. The next write that starts from an idle bus is accepted normally.

In byte mode the top data pin becomes the least significant address bit. The upper data byte then stays undriven. A separate reset output holds the command state machine in read-array mode during power-up and while the hardware reset pin is low.

Top module: `flash_bus_decoder`

## Requirements
- R1: While `rst_n` is low, and from the point the sampled `pin_rst_n` is low, `csm_reset` is 1, `bus_op` is 0 (reset), and `rd_strobe`, `dq_oe_lo` and `dq_oe_hi` are 0. This holds whatever the other pins do.
- R2: With chip enable low, output enable low and write enable high, the block reports `bus_op` = 3 (read) and raises `rd_strobe` and `dq_oe_lo`. In word mode it also raises `dq_oe_hi`, and `rd_addr` = {`pin_addr`, 1'b0}.
- R3: With chip enable high, `bus_op` is 1 (standby). With chip enable low and both output enable and write enable high, `bus_op` is 2 (output disable). In both cases both data enables are 0.
- R4: With chip enable low, write enable low and output enable high, `bus_op` is 4 (write). When that condition ends, exactly one single-cycle `wr_pulse` is issued. The pulse carries the address and data that were on the pins just before write enable rose.
- R5: No `wr_pulse` is issued for a write-enable pulse while output enable is low, or while chip enable is high.
- R6: A low pulse on a strobe that lasts fewer than `FILT_CYC` sampling cycles (default 4) is ignored. A pulse lasting `FILT_CYC` or more is acted upon.
- R7: If chip enable and write enable are low and output enable is high when reset is released, the write-enable rising edge that ends that condition produces no `wr_pulse`. Later writes are accepted.
- R8: In byte mode (`pin_byte_n` low), the address is formed as `wr_addr`/`rd_addr` = {`pin_addr`, `pin_dq_in[15]`] and `wr_data` = {8'h00, `pin_dq_in[7:0]`}. A read in this mode keeps `dq_oe_hi` at 0.
- R9: A write that is cut short by the hardware reset pin produces no `wr_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| pin_ce_n | input | 1 | Chip enable pin, active low |
| pin_oe_n | input | 1 | Output enable pin, active low |
| pin_we_n | input | 1 | Write enable pin, active low |
| pin_rst_n | input | 1 | Hardware reset pin, active low |
| pin_byte_n | input | 1 | Low selects byte mode, high selects word mode |
| pin_addr | input | ADDR_W | Word address pins |
| pin_dq_in | input | DQ_W | Data pins as seen by the input buffers |
| dq_oe_lo | output | 1 | Drive enable for data pins 0..7 |
| dq_oe_hi | output | 1 | Drive enable for data pins 8..15 |
| rd_strobe | output | 1 | Read access active |
| rd_addr | output | ADDR_W+1 | Byte address of the read |
| bus_op | output | 3 | Decoded operation: 0 reset, 1 standby, 2 disable, 3 read, 4 write |
| wr_pulse | output | 1 | One-cycle write-latch pulse to the command logic |
| wr_addr | output | ADDR_W+1 | Byte address captured for the write |
| wr_data | output | DQ_W | Data captured for the write |
| csm_reset | output | 1 | Holds the command state machine in read-array mode |

## Verification
A wrong filter count or synchroniser depth shows up on the ports in one of two ways. A short write-enable glitch produces a `wr_pulse`, or a valid strobe never reaches `bus_op` within the settle window of about a dozen cycles. A broken power-up interlock or a stale accept flag shows as a surplus or missing `wr_pulse` on the first write after reset or after a hardware reset. A wrong byte-mode steering shows at once on `dq_oe_hi` and in the low bit of `wr_addr`/`rd_addr` on the very next access.

// File: rtl/fbd_pkg.sv
package fbd_pkg;

  // decoded bus operation, codes visible on the bus_op port
  typedef enum logic [2:0] {
    OP_RESET   = 3'd0,
    OP_STANDBY = 3'd1,
    OP_DISABLE = 3'd2,
    OP_READ    = 3'd3,
    OP_WRITE   = 3'd4
  } bus_op_e;

  // sampled control pins, all active low
  typedef struct packed {
    logic ce_n;
    logic oe_n;
    logic we_n;
  } strobe_t;

  localparam int STROBE_N = 3;

endpackage

// File: rtl/fbd_sync.sv
module fbd_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  localparam int DEPTH = (STAGES < 2) ? 2 : STAGES;

  logic [DEPTH-1:0][W-1:0] pipe_q;
  logic [DEPTH-1:0][W-1:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[DEPTH-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q <= {DEPTH{RST_VAL}};
    end else begin
      pipe_q <= pipe_d;
    end
  end

  assign dout = pipe_q[DEPTH-1];

endmodule

// File: rtl/fbd_glitch_filter.sv
module fbd_glitch_filter #(
  parameter int   STABLE_CYC = 4,
  parameter logic RST_VAL    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);

  localparam int LIMIT = (STABLE_CYC < 2) ? 2 : STABLE_CYC;
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             filt_q, filt_d;

  // a new level is taken only after LIMIT consecutive differing samples
  always_comb begin
    cnt_d  = '0;
    filt_d = filt_q;
    if (raw != filt_q) begin
      if (cnt_q == LAST) begin
        filt_d = raw;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= RST_VAL;
    end else begin
      cnt_q  <= cnt_d;
      filt_q <= filt_d;
    end
  end

  assign filt = filt_q;

endmodule

// File: rtl/fbd_write_unit.sv
module fbd_write_unit #(
  parameter int ADDR_W = 19,
  parameter int DQ_W   = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hw_ok,
  input  logic            raw_wr_cond,
  input  logic            filt_wr_cond,
  input  logic [ADDR_W:0] addr_s,
  input  logic [DQ_W-1:0] data_s,
  output logic            wr_pulse,
  output logic [ADDR_W:0] wr_addr,
  output logic [DQ_W-1:0] wr_data,
  output logic            armed
);

  logic            act;
  logic            act_q;
  logic            accept_q, accept_d;
  logic            armed_q, armed_d;
  logic            pulse_q, pulse_d;
  logic            cap_en;
  logic [ADDR_W:0] cap_addr_q;
  logic [DQ_W-1:0] cap_data_q;

  assign act    = filt_wr_cond & hw_ok;
  assign cap_en = raw_wr_cond & hw_ok;

  always_comb begin
    // interlock: arm only once the bus has been seen idle after reset
    armed_d  = armed_q | (hw_ok & ~raw_wr_cond);
    accept_d = accept_q;
    if (!hw_ok) begin
      accept_d = 1'b0;
    end else if (act && !act_q) begin
      accept_d = armed_q;
    end
    pulse_d = act_q & ~act & accept_q & hw_ok;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q    <= 1'b0;
      accept_q <= 1'b0;
      armed_q  <= 1'b0;
      pulse_q  <= 1'b0;
    end else begin
      act_q    <= act;
      accept_q <= accept_d;
      armed_q  <= armed_d;
      pulse_q  <= pulse_d;
    end
  end

  // track the bus while the raw write condition holds; freezes at the rising strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else if (cap_en) begin
      cap_addr_q <= addr_s;
      cap_data_q <= data_s;
    end
  end

  assign wr_pulse = pulse_q;
  assign wr_addr  = cap_addr_q;
  assign wr_data  = cap_data_q;
  assign armed    = armed_q;

endmodule

// File: rtl/flash_bus_decoder.sv
module flash_bus_decoder #(
  parameter int ADDR_W      = 19,
  parameter int DQ_W        = 16,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_ce_n,
  input  logic              pin_oe_n,
  input  logic              pin_we_n,
  input  logic              pin_rst_n,
  input  logic              pin_byte_n,
  input  logic [ADDR_W-1:0] pin_addr,
  input  logic [DQ_W-1:0]   pin_dq_in,
  output logic              dq_oe_lo,
  output logic              dq_oe_hi,
  output logic              rd_strobe,
  output logic [ADDR_W:0]   rd_addr,
  output logic [2:0]        bus_op,
  output logic              wr_pulse,
  output logic [ADDR_W:0]   wr_addr,
  output logic [DQ_W-1:0]   wr_data,
  output logic              csm_reset
);
  import fbd_pkg::*;

  localparam int BYTE_W = DQ_W / 2;
  localparam int CTRL_W = STROBE_N + 2;
  localparam int BUS_W  = ADDR_W + DQ_W;
  // strobes and byte select idle high, the reset pin samples as asserted
  localparam logic [CTRL_W-1:0] CTRL_RST = {1'b0, 1'b1, {STROBE_N{1'b1}}};

  // reset: asynchronous assert, synchronous release
  logic rst_sync_n;
  fbd_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .din(1'b1), .dout(rst_sync_n)
  );

  // control pin synchronisers
  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;
  strobe_t           strobe_s, strobe_f;
  logic              reset_pin_s, byte_n_s, byte_mode_s;

  assign ctrl_raw = {pin_rst_n, pin_byte_n, pin_ce_n, pin_oe_n, pin_we_n};

  fbd_sync #(.W(CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_RST)) u_ctrl_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(ctrl_raw), .dout(ctrl_s)
  );

  assign strobe_s    = ctrl_s[STROBE_N-1:0];
  assign byte_n_s    = ctrl_s[STROBE_N];
  assign reset_pin_s = ctrl_s[STROBE_N+1];
  assign byte_mode_s = ~byte_n_s;

  // address / data synchronisers
  logic [BUS_W-1:0]  bus_s;
  logic [ADDR_W-1:0] addr_s;
  logic [DQ_W-1:0]   dq_s;

  fbd_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_sync_n), .din({pin_addr, pin_dq_in}), .dout(bus_s)
  );

  assign addr_s = bus_s[BUS_W-1:DQ_W];
  assign dq_s   = bus_s[DQ_W-1:0];

  // strobe glitch filters, one per strobe
  for (genvar gi = 0; gi < STROBE_N; gi++) begin : g_filt
    fbd_glitch_filter #(.STABLE_CYC(FILT_CYC), .RST_VAL(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_sync_n), .raw(strobe_s[gi]), .filt(strobe_f[gi])
    );
  end

  // the reset pin sync resets to asserted, so hw_ok also marks a settled front end
  logic hw_ok;
  assign hw_ok = reset_pin_s;

  // byte-mode steering of address and data
  logic [ADDR_W:0] eff_addr;
  logic [DQ_W-1:0] eff_data;

  always_comb begin
    if (byte_mode_s) begin
      eff_addr = {addr_s, dq_s[DQ_W-1]};
      eff_data = {{(DQ_W-BYTE_W){1'b0}}, dq_s[BYTE_W-1:0]};
    end else begin
      eff_addr = {addr_s, 1'b0};
      eff_data = dq_s;
    end
  end

  // write conditions, raw (for capture/interlock) and filtered (for the cycle)
  logic raw_wr_cond, filt_wr_cond;
  logic we_f, we_s;
  logic armed;

  assign raw_wr_cond  = ~strobe_s.ce_n & ~strobe_s.we_n & strobe_s.oe_n;
  assign filt_wr_cond = ~strobe_f.ce_n & ~strobe_f.we_n & strobe_f.oe_n;
  assign we_f         = strobe_f.we_n;
  assign we_s         = strobe_s.we_n;

  fbd_write_unit #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_write (
    .clk(clk), .rst_n(rst_sync_n), .hw_ok(hw_ok),
    .raw_wr_cond(raw_wr_cond), .filt_wr_cond(filt_wr_cond),
    .addr_s(eff_addr), .data_s(eff_data),
    .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data), .armed(armed)
  );

  // operation decode: next state
  bus_op_e         op_q, op_d;
  logic            oe_lo_q, oe_lo_d;
  logic            oe_hi_q, oe_hi_d;
  logic            csm_rst_q, csm_rst_d;
  logic [ADDR_W:0] rd_addr_q, rd_addr_d;
  logic            rd_addr_en;

  always_comb begin
    if (!hw_ok) begin
      op_d = OP_RESET;
    end else if (strobe_f.ce_n) begin
      op_d = OP_STANDBY;
    end else if (!strobe_f.we_n && strobe_f.oe_n) begin
      op_d = OP_WRITE;
    end else if (!strobe_f.oe_n && strobe_f.we_n) begin
      op_d = OP_READ;
    end else begin
      op_d = OP_DISABLE;
    end
    oe_lo_d    = (op_d == OP_READ);
    oe_hi_d    = (op_d == OP_READ) & ~byte_mode_s;
    csm_rst_d  = ~hw_ok;
    rd_addr_d  = eff_addr;
    rd_addr_en = hw_ok;
  end

  // operation decode: registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q      <= OP_RESET;
      oe_lo_q   <= 1'b0;
      oe_hi_q   <= 1'b0;
      csm_rst_q <= 1'b1;
    end else begin
      op_q      <= op_d;
      oe_lo_q   <= oe_lo_d;
      oe_hi_q   <= oe_hi_d;
      csm_rst_q <= csm_rst_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_addr_q <= '0;
    end else if (rd_addr_en) begin
      rd_addr_q <= rd_addr_d;
    end
  end

  assign bus_op    = op_q;
  assign dq_oe_lo  = oe_lo_q;
  assign dq_oe_hi  = oe_hi_q;
  assign rd_strobe = (op_q == OP_READ);
  assign rd_addr   = rd_addr_q;
  assign csm_reset = csm_rst_q;

endmodule

// File: rtl/fbd_checker.sv
module fbd_checker (
  input logic clk,
  input logic rst_n,
  input logic csm_reset,
  input logic dq_oe_lo,
  input logic dq_oe_hi,
  input logic rd_strobe,
  input logic wr_pulse,
  input logic byte_mode_s,
  input logic we_f,
  input logic we_s,
  input logic armed
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csm_reset |-> (!dq_oe_lo && !dq_oe_hi && !rd_strobe));

  // R2
  read_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_strobe |-> dq_oe_lo);

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |=> !wr_pulse);

  // R6
  filter_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_f) |-> (!$past(we_s) && !$past(we_s, 2)));

  // R7
  interlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pulse |-> armed);

  // R8
  byte_hi_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe_hi |-> !$past(byte_mode_s));

endmodule

bind flash_bus_decoder fbd_checker u_fbd_chk (
  .clk(clk),
  .rst_n(rst_sync_n),
  .csm_reset(csm_reset),
  .dq_oe_lo(dq_oe_lo),
  .dq_oe_hi(dq_oe_hi),
  .rd_strobe(rd_strobe),
  .wr_pulse(wr_pulse),
  .byte_mode_s(byte_mode_s),
  .we_f(we_f),
  .we_s(we_s),
  .armed(armed)
);

// File: tb/flash_bus_decoder_bench.sv
`timescale 1ns/1ps
module flash_bus_decoder_bench;

  localparam int ADDR_W = 19;
  localparam int DQ_W   = 16;
  localparam int SETTLE = 14;

  logic              clk;
  logic              rst_n;
  logic              pin_ce_n, pin_oe_n, pin_we_n, pin_rst_n, pin_byte_n;
  logic [ADDR_W-1:0] pin_addr;
  logic [DQ_W-1:0]   pin_dq_in;
  logic              dq_oe_lo, dq_oe_hi, rd_strobe, wr_pulse, csm_reset;
  logic [ADDR_W:0]   rd_addr, wr_addr;
  logic [2:0]        bus_op;
  logic [DQ_W-1:0]   wr_data;

  flash_bus_decoder #(.ADDR_W(ADDR_W), .DQ_W(DQ_W)) u_flash_bus_decoder (
    .clk(clk), .rst_n(rst_n),
    .pin_ce_n(pin_ce_n), .pin_oe_n(pin_oe_n), .pin_we_n(pin_we_n),
    .pin_rst_n(pin_rst_n), .pin_byte_n(pin_byte_n),
    .pin_addr(pin_addr), .pin_dq_in(pin_dq_in),
    .dq_oe_lo(dq_oe_lo), .dq_oe_hi(dq_oe_hi), .rd_strobe(rd_strobe),
    .rd_addr(rd_addr), .bus_op(bus_op), .wr_pulse(wr_pulse),
    .wr_addr(wr_addr), .wr_data(wr_data), .csm_reset(csm_reset)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int tests  = 0;
  int fails  = 0;
  int pulses = 0;
  logic [ADDR_W:0] last_addr;
  logic [DQ_W-1:0] last_data;
  bit done = 0;

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (wr_pulse === 1'b1) begin
      pulses    <= pulses + 1;
      last_addr <= wr_addr;
      last_data <= wr_data;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic sample();
    @(negedge clk);
  endtask

  task automatic idle_pins();
    pin_ce_n = 1'b1; pin_oe_n = 1'b1; pin_we_n = 1'b1;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [DQ_W-1:0] d, input int low_cyc);
    cycles(1);
    pin_addr = a; pin_dq_in = d; pin_oe_n = 1'b1; pin_ce_n = 1'b0;
    cycles(1);
    pin_we_n = 1'b0;
    cycles(low_cyc);
    pin_we_n = 1'b1;
    cycles(2);
    pin_ce_n = 1'b1; pin_dq_in = '0;
    cycles(SETTLE);
  endtask

  task automatic t_reset_state();
    sample();
    check("R1 csm_reset in reset", 32'(csm_reset), 1);
    check("R1 bus_op in reset", 32'(bus_op), 0);
    check("R1 enables in reset", 32'({dq_oe_hi, dq_oe_lo, rd_strobe}), 0);
    cycles(1);
    rst_n = 1'b1;
    cycles(SETTLE);
    sample();
    check("R1 csm_reset released", 32'(csm_reset), 0);
    check("R3 standby after reset", 32'(bus_op), 1);
  endtask

  task automatic t_read_word();
    cycles(1);
    pin_byte_n = 1'b1; pin_addr = 19'h12345; pin_ce_n = 1'b0; pin_oe_n = 1'b0;
    cycles(SETTLE);
    sample();
    check("R2 bus_op read", 32'(bus_op), 3);
    check("R2 rd_strobe", 32'(rd_strobe), 1);
    check("R2 word enables", 32'({dq_oe_hi, dq_oe_lo}), 3);
    check("R2 rd_addr word", 32'(rd_addr), 32'({19'h12345, 1'b0}));
    cycles(1);
    pin_oe_n = 1'b1;
    cycles(SETTLE);
    sample();
    check("R3 output disable op", 32'(bus_op), 2);
    check("R3 disable enables off", 32'({dq_oe_hi, dq_oe_lo, rd_strobe}), 0);
    cycles(1);
    pin_ce_n = 1'b1;
    cycles(SETTLE);
    sample();
    check("R3 standby op", 32'(bus_op), 1);
  endtask

  task automatic t_write_word();
    int base = pulses;
    cycles(1);
    pin_byte_n = 1'b1; pin_addr = 19'h2A5C3; pin_dq_in = 16'hBEEF; pin_ce_n = 1'b0;
    cycles(1);
    pin_we_n = 1'b0;
    cycles(10);
    sample();
    check("R4 bus_op write", 32'(bus_op), 4);
    cycles(1);
    pin_we_n = 1'b1;
    cycles(2);
    pin_ce_n = 1'b1; pin_dq_in = 16'h0000;
    cycles(SETTLE);
    sample();
    check("R4 one pulse", 32'(pulses - base), 1);
    check("R4 wr_addr", 32'(last_addr), 32'({19'h2A5C3, 1'b0}));
    check("R4 wr_data", 32'(last_data), 32'h0000BEEF);
  endtask

  task automatic t_byte_mode();
    int base = pulses;
    pin_byte_n = 1'b0;
    do_write(19'h00F0F, 16'hFFA5, 10);
    sample();
    check("R8 byte write pulse", 32'(pulses - base), 1);
    check("R8 byte wr_addr", 32'(last_addr), 32'({19'h00F0F, 1'b1}));
    check("R8 byte wr_data", 32'(last_data), 32'h000000A5);
    cycles(1);
    pin_addr = 19'h00111; pin_dq_in = 16'h8000; pin_ce_n = 1'b0; pin_oe_n = 1'b0;
    cycles(SETTLE);
    sample();
    check("R8 byte read enables", 32'({dq_oe_hi, dq_oe_lo}), 1);
    check("R8 byte rd_addr", 32'(rd_addr), 32'({19'h00111, 1'b1}));
    cycles(1);
    idle_pins(); pin_dq_in = '0; pin_byte_n = 1'b1;
    cycles(SETTLE);
  endtask

  task automatic t_inhibit();
    int base = pulses;
    cycles(1);
    pin_ce_n = 1'b0; pin_oe_n = 1'b0;
    cycles(1);
    pin_we_n = 1'b0;
    cycles(10);
    pin_we_n = 1'b1;
    cycles(2);
    idle_pins();
    cycles(SETTLE);
    sample();
    check("R5 no pulse with OE low", 32'(pulses - base), 0);
    cycles(1);
    pin_we_n = 1'b0;
    cycles(10);
    pin_we_n = 1'b1;
    cycles(SETTLE);
    sample();
    check("R5 no pulse with CE high", 32'(pulses - base), 0);
  endtask

  task automatic t_glitch();
    int base = pulses;
    do_write(19'h00001, 16'h1111, 3);
    sample();
    check("R6 short strobe ignored", 32'(pulses - base), 0);
    do_write(19'h00002, 16'h2222, 5);
    sample();
    check("R6 long strobe accepted", 32'(pulses - base), 1);
    check("R6 accepted data", 32'(last_data), 32'h00002222);
  endtask

  task automatic t_hw_reset();
    int base = pulses;
    cycles(1);
    pin_ce_n = 1'b0; pin_we_n = 1'b0;
    cycles(10);
    pin_rst_n = 1'b0;
    cycles(SETTLE);
    sample();
    check("R1 csm_reset on reset pin", 32'(csm_reset), 1);
    check("R1 bus_op on reset pin", 32'(bus_op), 0);
    cycles(1);
    pin_we_n = 1'b1; pin_oe_n = 1'b0;
    cycles(SETTLE);
    sample();
    check("R1 read blocked by reset pin", 32'({dq_oe_hi, dq_oe_lo, rd_strobe}), 0);
    cycles(1);
    idle_pins();
    pin_rst_n = 1'b1;
    cycles(SETTLE);
    sample();
    check("R9 aborted write no pulse", 32'(pulses - base), 0);
    check("R1 csm_reset released by pin", 32'(csm_reset), 0);
  endtask

  task automatic t_powerup();
    int base;
    cycles(1);
    rst_n = 1'b0;
    pin_ce_n = 1'b0; pin_we_n = 1'b0; pin_oe_n = 1'b1;
    cycles(3);
    rst_n = 1'b1;
    cycles(SETTLE);
    base = pulses;
    pin_we_n = 1'b1;
    cycles(2);
    pin_ce_n = 1'b1;
    cycles(SETTLE);
    sample();
    check("R7 power-up edge rejected", 32'(pulses - base), 0);
    do_write(19'h3FFFF, 16'h5A5A, 8);
    sample();
    check("R7 next write accepted", 32'(pulses - base), 1);
    check("R7 next write data", 32'(last_data), 32'h00005A5A);
  endtask

  initial begin
    rst_n = 1'b0; pin_rst_n = 1'b1; pin_byte_n = 1'b1;
    pin_addr = '0; pin_dq_in = '0;
    idle_pins();
    cycles(3);
    t_reset_state();
    t_read_word();
    t_write_word();
    t_byte_mode();
    t_inhibit();
    t_glitch();
    t_hw_reset();
    t_powerup();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule